// File: doc/BRIEF.md
# Conversion Trigger and Request Controller

This block decides when a digital filter channel starts a conversion. It serves two kinds of conversion. An inserted conversion is started by an edge on one of 32 external trigger lines. A 5-bit select value picks the line and a 2-bit mode picks the edge. A regular conversion is started by a software start strobe, or by a launch strobe from a master filter instance when synchronous launch is enabled. Regular conversions run either once per request or back-to-back until continuous mode is cleared.

The configuration fields (edge mode, trigger select, continuous mode and synchronous launch) are held in the block. They can be loaded only while the filter enable is low. The one exception is that continuous mode may be cleared at any time, which ends a running sequence at once. Each trigger line is marked synchronous or asynchronous at build time. A synchronous line is edge-detected directly. An asynchronous line first passes a multi-stage synchronizer. All start outputs are single-cycle pulses that go to the conversion engine, which reports back through a conversion-done strobe.

Top module: `conv_trig_ctrl`

## Requirements
- R1: The edge mode selects the trigger condition on the selected line: 2'b00 gives no request, 2'b01 gives a request on a rising edge, 2'b10 on a falling edge, and 2'b11 on either edge. Each qualifying edge gives one `inj_start` pulse.
- R2: The trigger select value N picks line `trig_in[N]`. Values 0 to 3 and 24 to 26 are valid. All other values never produce `inj_start`, whatever their line does.
- R3: A `cfg_we` strobe while `flt_en` is 1 leaves the edge mode, the trigger select and the synchronous-launch setting unchanged. Setting continuous mode is also refused while `flt_en` is 1. The stored values read back on `edge_mode`, `trig_sel`, `sync_mode` and `cont_mode`.
- R4: With continuous mode 0, an accepted regular request gives exactly one `reg_start` pulse one cycle after the request, and it sets `reg_pending`. `conv_done` then clears `reg_pending` without giving a further start.
- R5: With continuous mode 1, each `conv_done` while a request is pending gives another `reg_start` in the next cycle. `reg_pending` stays 1.
- R6: A `cfg_we` strobe with `cfg_cont`=0 while continuous mode is 1 clears continuous mode and `reg_pending` in the next cycle, even with `flt_en` at 1. No further `reg_start` follows.
- R7: A `sw_start` strobe while `reg_pending` is 1 is ignored and gives no `reg_start`.
- R8: With synchronous launch 1, a `master_start` strobe is a regular request. With synchronous launch 0, `master_start` is ignored.
- R9: A synchronous trigger line gives `inj_start` 1 cycle after its edge. An asynchronous line gives it ASYNC_STAGES+1 cycles after its edge, which is 3 cycles by default.
- R10: If an inserted start and a regular start fall due in the same cycle, `inj_start` is issued first. `reg_start` follows in the next cycle.
- R11: After reset, all outputs are 0 and no request is pending. No start pulse appears that the rules above do not call for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_en | input | 1 | Filter enable; gates requests and locks configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_edge | input | 2 | Edge mode to write |
| cfg_sel | input | 5 | Trigger select to write |
| cfg_cont | input | 1 | Continuous mode to write |
| cfg_sync | input | 1 | Synchronous launch enable to write |
| sw_start | input | 1 | Software regular-start strobe |
| master_start | input | 1 | Launch strobe from the master instance |
| trig_in | input | 32 | External trigger lines |
| conv_done | input | 1 | Conversion finished strobe from the engine |
| inj_start | output | 1 | Inserted conversion start pulse |
| reg_start | output | 1 | Regular conversion start pulse |
| reg_pending | output | 1 | Regular request pending |
| edge_mode | output | 2 | Stored edge mode |
| trig_sel | output | 5 | Stored trigger select |
| cont_mode | output | 1 | Stored continuous mode |
| sync_mode | output | 1 | Stored synchronous launch enable |

## Verification
The bench builds the block with SYNC_MASK = 32'h0000_000F and ASYNC_STAGES = 2. Lines 0 to 3 are therefore synchronous and lines 24 and 26 are asynchronous. With this build, the 1-cycle and 3-cycle trigger latencies are measured on real valid codes, and reserved codes 5 and 31 are checked for silence. The default depth also keeps the async timing exact to the cycle, so the scoreboard can predict every pulse. That includes the pulse deferred by an inserted-versus-regular collision.

// File: rtl/conv_trig_pkg.sv
package conv_trig_pkg;
  localparam int TRIG_SEL_W = 5;
  localparam int N_TRIG     = 1 << TRIG_SEL_W;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_t;

  // valid select codes: 0..3 and 24..26
  function automatic logic code_valid(input logic [TRIG_SEL_W-1:0] c);
    return (c <= 5'h03) || ((c >= 5'h18) && (c <= 5'h1A));
  endfunction

  function automatic logic edge_hit(input edge_mode_t m, input logic cur, input logic prv);
    case (m)
      EDGE_RISE: return cur & ~prv;
      EDGE_FALL: return ~cur & prv;
      EDGE_BOTH: return cur ^ prv;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/trig_cond.sv
module trig_cond #(
  parameter int N = 32,
  parameter logic [N-1:0] SYNC_MASK = '0,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] cur,
  output logic [N-1:0] prv
);
  for (genvar i = 0; i < N; i++) begin : g_line
    if (SYNC_MASK[i]) begin : g_sync
      assign cur[i] = raw[i];
    end else begin : g_async
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], raw[i]};
      end
      assign cur[i] = sh[STAGES-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) prv[i] <= 1'b0;
      else        prv[i] <= cur[i];
    end
  end
endmodule

// File: rtl/trig_select.sv
module trig_select
  import conv_trig_pkg::*;
(
  input  logic [N_TRIG-1:0]     cur,
  input  logic [N_TRIG-1:0]     prv,
  input  logic [TRIG_SEL_W-1:0] sel,
  input  edge_mode_t            mode,
  input  logic                  en,
  output logic                  ev
);
  logic c_bit, p_bit;
  assign c_bit = cur[sel];
  assign p_bit = prv[sel];
  assign ev = en & code_valid(sel) & edge_hit(mode, c_bit, p_bit);
endmodule

// File: rtl/reg_seq.sv
module reg_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic cont_on,
  input  logic cont_stop,
  input  logic done,
  input  logic inj_busy,
  output logic pending,
  output logic reg_start
);
  logic issue_q;

  assign reg_start = issue_q & ~inj_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      issue_q <= 1'b0;
    end else if (cont_stop) begin
      pending <= 1'b0;
      issue_q <= 1'b0;
    end else if (accept) begin
      pending <= 1'b1;
      issue_q <= 1'b1;
    end else if (done && pending && !cont_on) begin
      pending <= 1'b0;
      issue_q <= 1'b0;
    end else if (done && pending && cont_on) begin
      issue_q <= 1'b1;
    end else if (reg_start) begin
      issue_q <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_trig_ctrl.sv
module conv_trig_ctrl
  import conv_trig_pkg::*;
#(
  parameter logic [N_TRIG-1:0] SYNC_MASK = 32'h0000_000F,
  parameter int ASYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flt_en,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_edge,
  input  logic [TRIG_SEL_W-1:0] cfg_sel,
  input  logic                  cfg_cont,
  input  logic                  cfg_sync,
  input  logic                  sw_start,
  input  logic                  master_start,
  input  logic [N_TRIG-1:0]     trig_in,
  input  logic                  conv_done,
  output logic                  inj_start,
  output logic                  reg_start,
  output logic                  reg_pending,
  output logic [1:0]            edge_mode,
  output logic [TRIG_SEL_W-1:0] trig_sel,
  output logic                  cont_mode,
  output logic                  sync_mode
);
  edge_mode_t edge_q;
  logic [N_TRIG-1:0] cur, prv;
  logic trig_ev, accept, cont_stop, reg_req;

  // configuration store: locked while enabled, except clearing continuous mode
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q    <= EDGE_OFF;
      trig_sel  <= '0;
      cont_mode <= 1'b0;
      sync_mode <= 1'b0;
    end else if (cfg_we) begin
      if (!flt_en) begin
        edge_q    <= edge_mode_t'(cfg_edge);
        trig_sel  <= cfg_sel;
        cont_mode <= cfg_cont;
        sync_mode <= cfg_sync;
      end else if (!cfg_cont) begin
        cont_mode <= 1'b0;
      end
    end
  end
  assign edge_mode = edge_q;

  trig_cond #(.N(N_TRIG), .SYNC_MASK(SYNC_MASK), .STAGES(ASYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .raw(trig_in), .cur(cur), .prv(prv)
  );

  trig_select u_sel (
    .cur(cur), .prv(prv), .sel(trig_sel), .mode(edge_q), .en(flt_en), .ev(trig_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) inj_start <= 1'b0;
    else        inj_start <= trig_ev;
  end

  assign reg_req   = sw_start | (sync_mode & master_start);
  assign accept    = flt_en & reg_req & ~reg_pending;
  assign cont_stop = cfg_we & ~cfg_cont & cont_mode;

  reg_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .cont_on(cont_mode),
    .cont_stop(cont_stop), .done(conv_done), .inj_busy(inj_start),
    .pending(reg_pending), .reg_start(reg_start)
  );
endmodule

// File: rtl/conv_trig_chk.sv
module conv_trig_chk
  import conv_trig_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flt_en,
  input logic                  cfg_we,
  input logic                  cfg_cont,
  input logic                  cont_mode,
  input logic                  sync_mode,
  input logic [1:0]            edge_mode,
  input logic [TRIG_SEL_W-1:0] trig_sel,
  input logic                  inj_start,
  input logic                  reg_start,
  input logic                  reg_pending,
  input logic                  trig_ev,
  input logic                  accept
);
  assert_start_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inj_start, reg_start}));

  assert_start_needs_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_start |-> reg_pending);

  assert_reserved_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid(trig_sel) |=> !inj_start);

  assert_cfg_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flt_en |=> ($stable(edge_mode) && $stable(trig_sel) && $stable(sync_mode)));

  assert_cont_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_cont && cont_mode) |=> (!reg_pending && !cont_mode));

  assert_edge_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode == 2'b00) |=> !inj_start);

  assert_accept_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(cfg_we && !cfg_cont && cont_mode)) |=> reg_pending);

  assert_trig_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ev |=> inj_start);
endmodule

bind conv_trig_ctrl conv_trig_chk u_chk (.*);

// File: tb/test_conv_trig_ctrl.sv
module test_conv_trig_ctrl;
  import conv_trig_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, flt_en, cfg_we, cfg_cont, cfg_sync, sw_start, master_start, conv_done;
  logic [1:0] cfg_edge;
  logic [4:0] cfg_sel;
  logic [31:0] trig_in;
  logic inj_start, reg_start, reg_pending, cont_mode, sync_mode;
  logic [1:0] edge_mode;
  logic [4:0] trig_sel;

  conv_trig_ctrl #(.SYNC_MASK(32'h0000_000F), .ASYNC_STAGES(2)) i_conv_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .flt_en(flt_en), .cfg_we(cfg_we), .cfg_edge(cfg_edge),
    .cfg_sel(cfg_sel), .cfg_cont(cfg_cont), .cfg_sync(cfg_sync), .sw_start(sw_start),
    .master_start(master_start), .trig_in(trig_in), .conv_done(conv_done),
    .inj_start(inj_start), .reg_start(reg_start), .reg_pending(reg_pending),
    .edge_mode(edge_mode), .trig_sel(trig_sel), .cont_mode(cont_mode), .sync_mode(sync_mode)
  );

  typedef struct { int c; bit inj; bit rg; string tag; } item_t;
  item_t q[$];
  int cyc = 0;
  int vec = 0;
  int bad = 0;
  bit mon = 0;
  bit ended = 0;

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  // monitor: every cycle compares both start outputs with the scoreboard
  always begin
    bit ei, er;
    string t;
    @(posedge clk);
    #5;
    if (mon) begin
      cyc++;
      ei = 0; er = 0; t = "R11";
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].c == cyc) begin
          ei |= q[i].inj; er |= q[i].rg; t = q[i].tag;
          q.delete(i);
        end
      end
      vec++;
      if (inj_start !== ei || reg_start !== er) begin
        bad++;
        $display("FAIL %s cycle %0d: inj=%b reg=%b expected inj=%b reg=%b",
                 t, cyc, inj_start, reg_start, ei, er);
      end
    end
  end

  task automatic expect_at(input int dly, input bit inj, input bit rg, input string tag);
    item_t it;
    it.c = cyc + dly; it.inj = inj; it.rg = rg; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic nc(); @(negedge clk); endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic cfg(input logic [1:0] e, input logic [4:0] s, input logic c, input logic y);
    nc(); flt_en = 0; cfg_we = 1; cfg_edge = e; cfg_sel = s; cfg_cont = c; cfg_sync = y;
    nc(); cfg_we = 0; flt_en = 1;
    idle(4);
  endtask

  task automatic sw_pulse(input bit accepted, input string tag);
    nc(); sw_start = 1;
    if (accepted) expect_at(1, 0, 1, tag);
    nc(); sw_start = 0;
  endtask

  task automatic done_pulse(input bit restart, input string tag);
    nc(); conv_done = 1;
    if (restart) expect_at(1, 0, 1, tag);
    nc(); conv_done = 0;
  endtask

  task automatic edge_to(input int idx, input bit v, input int dly, input bit hit, input string tag);
    nc(); trig_in[idx] = v;
    if (hit) expect_at(dly, 1, 0, tag);
    idle(6);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL R11: watchdog expired, actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; flt_en = 0; cfg_we = 0; cfg_edge = 0; cfg_sel = 0; cfg_cont = 0; cfg_sync = 0;
    sw_start = 0; master_start = 0; conv_done = 0; trig_in = '0;
    idle(4);
    // R11 reset state
    chk("R11 inj", {31'b0, inj_start}, 0);
    chk("R11 reg", {31'b0, reg_start}, 0);
    chk("R11 pending", {31'b0, reg_pending}, 0);
    chk("R11 cfg", {24'b0, edge_mode, trig_sel, cont_mode}, 0);
    nc(); rst_n = 1; mon = 1;
    idle(2);

    // R1 rising edges on sync line 0 (R9 sync latency 1)
    cfg(2'b01, 5'd0, 0, 0);
    edge_to(0, 1, 1, 1, "R1 rise");
    edge_to(0, 0, 1, 0, "R1 rise-only");
    // R3 writes while enabled are ignored
    nc(); cfg_we = 1; cfg_edge = 2'b11; cfg_sel = 5'd5; cfg_cont = 1; cfg_sync = 1;
    nc(); cfg_we = 0;
    idle(2);
    chk("R3 edge", {30'b0, edge_mode}, 1);
    chk("R3 sel", {27'b0, trig_sel}, 0);
    chk("R3 cont/sync", {30'b0, cont_mode, sync_mode}, 0);
    // R1 falling mode
    cfg(2'b10, 5'd0, 0, 0);
    edge_to(0, 1, 1, 0, "R1 fall");
    edge_to(0, 0, 1, 1, "R1 fall");
    // R1 both edges, on line 3
    cfg(2'b11, 5'd3, 0, 0);
    edge_to(3, 1, 1, 1, "R1 both");
    edge_to(3, 0, 1, 1, "R1 both");
    // R1 detection off
    cfg(2'b00, 5'd3, 0, 0);
    edge_to(3, 1, 1, 0, "R1 off");
    edge_to(3, 0, 1, 0, "R1 off");

    // R9 asynchronous line 24 takes 3 cycles
    cfg(2'b01, 5'h18, 0, 0);
    edge_to(24, 1, 3, 1, "R9 async");
    edge_to(24, 0, 3, 0, "R9 async");
    // R2 valid code 26 and reserved codes 5, 31
    cfg(2'b11, 5'h1A, 0, 0);
    edge_to(26, 1, 3, 1, "R2 valid26");
    edge_to(26, 0, 3, 1, "R2 valid26");
    cfg(2'b11, 5'd5, 0, 0);
    edge_to(5, 1, 1, 0, "R2 reserved5");
    edge_to(5, 0, 1, 0, "R2 reserved5");
    cfg(2'b11, 5'h1F, 0, 0);
    edge_to(31, 1, 3, 0, "R2 reserved31");
    edge_to(31, 0, 3, 0, "R2 reserved31");

    // R4 single mode, R7 dropped start while pending
    cfg(2'b00, 5'd0, 0, 0);
    sw_pulse(1, "R4 single");
    idle(2);
    chk("R4 pending set", {31'b0, reg_pending}, 1);
    sw_pulse(0, "R7 dropped");
    idle(2);
    done_pulse(0, "R4 done");
    chk("R4 pending clear", {31'b0, reg_pending}, 0);
    sw_pulse(1, "R4 again");
    idle(2);
    done_pulse(0, "R4 done");

    // R5 continuous repeats on each done
    cfg(2'b00, 5'd0, 1, 0);
    chk("R5 cont stored", {31'b0, cont_mode}, 1);
    sw_pulse(1, "R5 first");
    idle(3);
    done_pulse(1, "R5 repeat");
    idle(2);
    sw_pulse(0, "R7 cont pending");
    done_pulse(1, "R5 repeat");
    idle(2);
    chk("R5 pending held", {31'b0, reg_pending}, 1);
    // R6 clearing continuous while enabled stops the sequence
    nc(); cfg_we = 1; cfg_cont = 0; cfg_edge = 2'b00; cfg_sel = 5'd0; cfg_sync = 0;
    nc(); cfg_we = 0;
    chk("R6 pending", {31'b0, reg_pending}, 0);
    chk("R6 cont", {31'b0, cont_mode}, 0);
    done_pulse(0, "R6 no restart");
    idle(3);

    // R8 master launch
    cfg(2'b00, 5'd0, 0, 1);
    nc(); master_start = 1; expect_at(1, 0, 1, "R8 master");
    nc(); master_start = 0;
    idle(2);
    done_pulse(0, "R8 done");
    cfg(2'b00, 5'd0, 0, 0);
    nc(); master_start = 1;
    nc(); master_start = 0;
    idle(2);
    chk("R8 ignored", {31'b0, reg_pending}, 0);

    // R10 inserted first on collision
    cfg(2'b01, 5'd1, 0, 0);
    nc(); trig_in[1] = 1; sw_start = 1;
    expect_at(1, 1, 0, "R10 inj first");
    expect_at(2, 0, 1, "R10 reg deferred");
    nc(); sw_start = 0;
    idle(4);
    done_pulse(0, "R10 done");
    idle(5);

    chk("R11 scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule